// File: doc/BRIEF.md
# Gated Continuous-Scan Queue Sequencer

This block walks a table of conversion commands for as long as an external gate stays open. For each command it sends a one-cycle start pulse to a conversion engine and waits for that engine's done pulse. When the queue ends, it raises a completion flag, wraps back to the first command and keeps converting. A queue ends either at an entry holding the end-of-queue code or after the last table index has been converted.

If a second completion occurs while the completion flag is still set, the block raises a trigger overrun flag. The gate is examined only when a conversion finishes. If the gate is closed at that point, the block finishes the conversion, stops and raises an incomplete-queue flag. A pointer holds the index of the last conversion that finished, so software can locate where a stopped queue ended. Reopening the gate always restarts at the first command. Clearing the mode enable halts the block at once.

The command table sits outside the block. The table is read through the index output and returns the selected entry on the code input in the same cycle.

Top module: `gscan_seq`

## Requirements
- R1: Each conversion is requested by a start pulse exactly one cycle long. The command index is held until the matching done pulse arrives, and no new start is issued before it.
- R2: When the queue ends while the gate is open, the completion flag is set, the index returns to 0 and conversions continue without a break.
- R3: A completion that occurs while the completion flag is already set (its state before that cycle) also sets the trigger overrun flag.
- R4: The gate is sampled only in the cycle a done pulse is accepted. A gate closure that lies wholly between two such cycles has no effect.
- R5: If the gate is found closed at a done and the queue has not ended, the block issues no further start and sets the incomplete-queue flag. If that conversion was the last one of the queue, the completion flag is set instead and the incomplete-queue flag stays clear.
- R6: The last-valid output equals the index of the most recent conversion whose done was accepted.
- R7: Every run that starts from stopped begins its first conversion at index 0.
- R8: When the enable is low, the block stops within one cycle, sets no flag and ignores a done that is still in flight. The index returns to 0.
- R9: Each flag is sticky and is cleared only by its own clear strobe. A set and a clear in the same cycle leave the flag set.
- R10: An entry whose code is all ones marks the end of the queue and is never converted. Without such an entry, the queue ends after index DEPTH-1.
- R11: After reset, all flags, the start output, the index and the last-valid pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Mode enable |
| gate_i | input | 1 | External gate, high = open |
| cmd_idx_o | output | IDX_W | Index of the current command entry |
| cmd_code_i | input | CODE_W | Table entry at cmd_idx_o; all ones = end of queue |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_done_i | input | 1 | One-cycle conversion finished pulse |
| clr_cf_i | input | 1 | Clear strobe, completion flag |
| clr_tor_i | input | 1 | Clear strobe, trigger overrun flag |
| clr_pf_i | input | 1 | Clear strobe, incomplete-queue flag |
| cf_o | output | 1 | Completion flag |
| tor_o | output | 1 | Trigger overrun flag |
| pf_o | output | 1 | Incomplete-queue flag |
| last_valid_o | output | IDX_W | Index of last completed conversion |

## Verification
A start appears one cycle after the gate is first seen open, and again one cycle after each accepted done. An end-of-queue entry costs one extra cycle before the completion flag sets. The completion flag sets at the done edge when the last index is reached. The incomplete-queue flag sets one edge after the done that found the gate closed. The last-valid pointer updates on the done edge itself. The bench drives inputs and samples outputs on the falling edge. After every run it waits several cycles beyond the stub latency, so all of these results have settled. It checks the restart index in the same cycle the start pulse is seen.

// File: rtl/gscan_pkg.sv
package gscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    IDX_HOLD = 2'd0,
    IDX_ZERO = 2'd1,
    IDX_INC  = 2'd2
  } idx_op_e;

  localparam int unsigned NFLAG    = 3;
  localparam int unsigned FLAG_CF  = 0;
  localparam int unsigned FLAG_TOR = 1;
  localparam int unsigned FLAG_PF  = 2;
endpackage

// File: rtl/gscan_idx.sv
module gscan_idx
  import gscan_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  idx_op_e          op_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             at_last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else begin
      unique case (op_i)
        IDX_ZERO: idx_q <= '0;
        IDX_INC:  idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        default:  idx_q <= idx_q;
      endcase
    end
  end

  assign idx_o     = idx_q;
  assign at_last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/gscan_flags.sv
module gscan_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;  // set wins over clear
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/gscan_ctrl.sv
module gscan_ctrl
  import gscan_pkg::*;
#(
  parameter int unsigned CODE_W = 6,
  localparam logic [CODE_W-1:0] EOQ_CODE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              gate_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              done_i,
  input  logic              at_last_i,
  input  logic              cf_q_i,
  output idx_op_e           idx_op_o,
  output logic              start_o,
  output logic              lv_load_o,
  output logic [NFLAG-1:0]  set_o
);
  seq_state_e state_q, state_d;
  logic       stop_q, stop_d;
  logic       comp, comp_go;

  always_comb begin
    state_d   = state_q;
    stop_d    = stop_q;
    idx_op_o  = IDX_HOLD;
    start_o   = 1'b0;
    lv_load_o = 1'b0;
    set_o     = '0;
    comp      = 1'b0;
    comp_go   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        idx_op_o = IDX_ZERO;
        stop_d   = 1'b0;
        if (en_i && gate_i) state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (!en_i) begin
          state_d  = ST_IDLE;
          idx_op_o = IDX_ZERO;
        end else if (code_i == EOQ_CODE) begin
          comp    = 1'b1;
          comp_go = !stop_q;  // gate as seen at the last done
        end else if (stop_q) begin
          set_o[FLAG_PF] = 1'b1;
          state_d        = ST_IDLE;
          idx_op_o       = IDX_ZERO;
        end else begin
          start_o = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!en_i) begin
          state_d  = ST_IDLE;
          idx_op_o = IDX_ZERO;
        end else if (done_i) begin
          lv_load_o = 1'b1;
          if (at_last_i) begin
            comp    = 1'b1;
            comp_go = gate_i;
          end else begin
            idx_op_o = IDX_INC;
            stop_d   = !gate_i;
            state_d  = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (comp) begin
      set_o[FLAG_CF]  = 1'b1;
      set_o[FLAG_TOR] = cf_q_i;
      idx_op_o        = IDX_ZERO;
      stop_d          = 1'b0;
      state_d         = comp_go ? ST_ISSUE : ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
    end
  end
endmodule

// File: rtl/gscan_seq.sv
module gscan_seq
  import gscan_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              gate_i,
  output logic [IDX_W-1:0]  cmd_idx_o,
  input  logic [CODE_W-1:0] cmd_code_i,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic              clr_cf_i,
  input  logic              clr_tor_i,
  input  logic              clr_pf_i,
  output logic              cf_o,
  output logic              tor_o,
  output logic              pf_o,
  output logic [IDX_W-1:0]  last_valid_o
);
  idx_op_e          idx_op;
  logic             at_last;
  logic             lv_load;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic [IDX_W-1:0] lv_q;

  gscan_idx #(.DEPTH(DEPTH)) u_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (idx_op),
    .idx_o     (cmd_idx_o),
    .at_last_o (at_last)
  );

  gscan_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .gate_i    (gate_i),
    .code_i    (cmd_code_i),
    .done_i    (conv_done_i),
    .at_last_i (at_last),
    .cf_q_i    (flag_q[FLAG_CF]),
    .idx_op_o  (idx_op),
    .start_o   (conv_start_o),
    .lv_load_o (lv_load),
    .set_o     (flag_set)
  );

  always_comb begin
    flag_clr           = '0;
    flag_clr[FLAG_CF]  = clr_cf_i;
    flag_clr[FLAG_TOR] = clr_tor_i;
    flag_clr[FLAG_PF]  = clr_pf_i;
  end

  gscan_flags #(.N(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lv_q <= '0;
    else if (lv_load) lv_q <= cmd_idx_o;
  end

  assign cf_o         = flag_q[FLAG_CF];
  assign tor_o        = flag_q[FLAG_TOR];
  assign pf_o         = flag_q[FLAG_PF];
  assign last_valid_o = lv_q;
endmodule

// File: rtl/gscan_seq_chk.sv
module gscan_seq_chk #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  cmd_idx_o,
  input logic [CODE_W-1:0] cmd_code_i,
  input logic              conv_start_o,
  input logic              conv_done_i,
  input logic              clr_cf_i,
  input logic              cf_o,
  input logic              tor_o,
  input logic              pf_o,
  input logic [IDX_W-1:0]  last_valid_o
);
  p_start_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_idx_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> $stable(cmd_idx_o));

  p_overrun_needs_cf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tor_o) |-> $past(cf_o));

  p_stop_no_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_o) |-> !conv_start_o);

  p_lv_on_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_valid_o) |-> $past(conv_done_i));

  p_cf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_o && !clr_cf_i) |=> cf_o);

  p_eoq_not_started_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (cmd_code_i != '1));
endmodule

bind gscan_seq gscan_seq_chk #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_idx_o    (cmd_idx_o),
  .cmd_code_i   (cmd_code_i),
  .conv_start_o (conv_start_o),
  .conv_done_i  (conv_done_i),
  .clr_cf_i     (clr_cf_i),
  .cf_o         (cf_o),
  .tor_o        (tor_o),
  .pf_o         (pf_o),
  .last_valid_o (last_valid_o)
);

// File: tb/gscan_seq_bench.sv
module gscan_seq_bench;
  localparam int DEPTH  = 8;
  localparam int CODE_W = 4;
  localparam int IDX_W  = 3;
  localparam int LAT    = 4;
  localparam logic [CODE_W-1:0] EOQ = '1;
  localparam int NVEC   = 6;
  // {queue length (DEPTH = no end code), conversions while open}
  localparam int VEC [NVEC][2] = '{'{3, 7}, '{3, 3}, '{3, 6}, '{8, 5}, '{8, 8}, '{8, 17}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              en = 1'b0, gate = 1'b0;
  logic              clr_cf = 1'b0, clr_tor = 1'b0, clr_pf = 1'b0;
  logic [IDX_W-1:0]  cmd_idx, last_valid;
  logic [CODE_W-1:0] cmd_code;
  logic              conv_start, conv_done, cf, tor, pf;
  logic [CODE_W-1:0] tbl [DEPTH];

  assign cmd_code = tbl[cmd_idx];

  gscan_seq #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_gscan_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .gate_i(gate),
    .cmd_idx_o(cmd_idx), .cmd_code_i(cmd_code),
    .conv_start_o(conv_start), .conv_done_i(conv_done),
    .clr_cf_i(clr_cf), .clr_tor_i(clr_tor), .clr_pf_i(clr_pf),
    .cf_o(cf), .tor_o(tor), .pf_o(pf), .last_valid_o(last_valid)
  );

  // conversion engine stub
  int lat_cnt;
  int n_starts, n_eoq_starts;
  logic cnt_rst = 1'b0;
  assign conv_done = (lat_cnt == 1);
  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= 0;
    else if (conv_start) lat_cnt <= LAT;
    else if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
    if (cnt_rst) begin
      n_starts <= 0;
      n_eoq_starts <= 0;
    end else if (conv_start) begin
      n_starts <= n_starts + 1;
      if (cmd_code == EOQ) n_eoq_starts <= n_eoq_starts + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_tbl(input int len);
    for (int i = 0; i < DEPTH; i++) tbl[i] = (i == len) ? EOQ : CODE_W'(i);
  endtask

  task automatic reset_counts();
    @(negedge clk); cnt_rst = 1'b1;
    @(negedge clk); cnt_rst = 1'b0;
  endtask

  task automatic wait_starts(input int n);
    while (n_starts < n) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr_cf = 1'b1; clr_tor = 1'b1; clr_pf = 1'b1;
    @(negedge clk); clr_cf = 1'b0; clr_tor = 1'b0; clr_pf = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    load_tbl(DEPTH);
    cnt_rst = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cf", int'(cf), 0);
    chk("R11 tor", int'(tor), 0);
    chk("R11 pf", int'(pf), 0);
    chk("R11 start", int'(conv_start), 0);
    chk("R11 idx", int'(cmd_idx), 0);
    chk("R11 lv", int'(last_valid), 0);
    rst_n = 1'b1;
    cnt_rst = 1'b0;
    en = 1'b1;

    // vector table: completion, overrun, stop, pointer
    for (int v = 0; v < NVEC; v++) begin
      automatic int len = VEC[v][0];
      automatic int n = VEC[v][1];
      automatic int comps = n / len;
      load_tbl(len);
      reset_counts();
      gate = 1'b1;
      wait_starts(n);
      gate = 1'b0;
      repeat (LAT + 6) @(negedge clk);
      chk("R1 start count", n_starts, n);
      chk("R10 eoq never started", n_eoq_starts, 0);
      chk("R2 cf", int'(cf), int'(comps >= 1));
      chk("R3 tor", int'(tor), int'(comps >= 2));
      chk("R5 pf", int'(pf), int'((n % len) != 0));
      chk("R6 last valid", int'(last_valid), (n - 1) % len);
      chk("R7 idx back to 0", int'(cmd_idx), 0);
      clear_all();
      chk("R9 flags cleared", int'({cf, tor, pf}), 0);
    end

    // R4: short gate closure between done edges is not seen
    load_tbl(DEPTH);
    reset_counts();
    gate = 1'b1;
    wait_starts(2);
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    wait_starts(5);
    gate = 1'b0;
    repeat (LAT + 6) @(negedge clk);
    chk("R4 glitch ignored, starts", n_starts, 5);
    chk("R4 pf", int'(pf), 1);
    chk("R4 last valid", int'(last_valid), 4);

    // R7: reopening after incomplete stop restarts at index 0
    @(negedge clk); gate = 1'b1;
    while (!conv_start) @(negedge clk);
    chk("R7 restart index", int'(cmd_idx), 0);
    gate = 1'b0;
    repeat (LAT + 6) @(negedge clk);
    chk("R6 lv after restart", int'(last_valid), 0);
    chk("R9 pf sticky", int'(pf), 1);
    clear_all();

    // R3: cleared completion flag prevents overrun
    load_tbl(3);
    reset_counts();
    clr_cf = 1'b1;
    gate = 1'b1;
    wait_starts(9);
    gate = 1'b0;
    clr_cf = 1'b0;
    repeat (LAT + 6) @(negedge clk);
    chk("R3 no tor when cf cleared", int'(tor), 0);
    chk("R2 cf on final pass", int'(cf), 1);
    chk("R5 no pf at queue end", int'(pf), 0);
    clear_all();

    // R8: disable stops immediately, in-flight done ignored
    load_tbl(DEPTH);
    reset_counts();
    gate = 1'b1;
    wait_starts(3);
    en = 1'b0;
    repeat (LAT + 6) @(negedge clk);
    chk("R8 starts stop", n_starts, 3);
    chk("R8 no pf", int'(pf), 0);
    chk("R8 lv ignores in-flight done", int'(last_valid), 1);
    chk("R8 idx 0", int'(cmd_idx), 0);
    gate = 1'b0;
    en = 1'b1;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule